// File: doc/BRIEF.md
# Access Watchpoint Unit

The unit observes every memory access passing through an arbiter and compares it against four independent watch channels. Each channel is set up with an inclusive address window, a mask of access kinds and a mask of requesting clients. An access that meets all three conditions is a hit for that channel. The first hit takes a snapshot of the access, and the snapshot stays frozen until software releases it. Every hit also marks the channel's interrupt as pending.

Clearing is done in two levels. A global acknowledge register clears pending interrupt bits, and each channel has its own acknowledge that releases its snapshot. A shared enable register selects which pending bits drive the interrupt line. Software reads and writes everything through a flat register port: writes take effect on the clock edge and reads are combinational.

Each channel runs a two-state machine. ARMED has no snapshot. HELD has a frozen snapshot. The transitions are:
- CAPTURE: ARMED to HELD on a hit.
- ACCUMULATE: HELD to HELD on a hit without acknowledge. Only the client set grows.
- RELEASE: HELD to ARMED on an acknowledge with no hit.
- RECAPTURE: HELD to HELD on a hit together with an acknowledge. A fresh snapshot is loaded.

An acknowledge in ARMED does nothing.

Top module: `access_watch_unit`

## Requirements
- R1: A channel hits only when its first address ≤ access address ≤ its last address. Both bounds are inclusive.
- R2: An access of operation code k (0..3) can hit only if bit k of the channel's operation mask is set.
- R3: An access from client id c can hit only if bit c of the channel's client mask is set. Client ids of 14 or more never hit.
- R4: On a hit in ARMED, the channel goes to HELD and captures five values: the address, the operation code, the client id as first client, the size, and a client set equal to the one-hot code of the client id.
- R5: While HELD, later hits change none of the captured fields except the client set. The client set gains the bit of each new hitting client.
- R6: Writing channel index 9 (acknowledge) in HELD with no simultaneous hit returns the channel to ARMED and zeroes its snapshot. The status field reads 0 afterwards.
- R7: Every hit sets the channel's pending bit. Writing 1 to bit n of the global acknowledge register clears pending bit n. A hit in the same cycle wins, and the bit stays set. The global acknowledge does not release the snapshot.
- R8: The global enable register holds one bit per channel. The masked status register reads pending AND enable. `irq` is the OR of the masked status bits.
- R9: A hit in the same cycle as a channel acknowledge in HELD loads a fresh snapshot of that hit, and the channel stays HELD.
- R10: Channels are independent. A hit on one channel changes no other channel's state, snapshot or pending bit.
- R11: After reset, every register reads zero, every channel is ARMED and `irq` is low.
- R12: Register address layout: bit 6 set selects global registers, clear selects a channel. Bits 5:4 hold the channel number and bits 3:0 the index.
  - Channel indices: 0 first, 1 last, 2 op mask, 3 client mask, 4 client set, 5 address, 6 op, 7 first client, 8 size, 9 acknowledge, 10 status (bit 0 = HELD).
  - Global indices: 0 enable, 1 masked status, 2 acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | 32 | Access address |
| acc_op | input | 2 | Access operation code |
| acc_client | input | 4 | Requesting client id |
| acc_size | input | 3 | Access size code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of enabled pending bits |

## Verification
The assertions check on every cycle that:
- a hit always sets pending and moves its channel to HELD;
- a global acknowledge without a hit clears the pending bit;
- a held snapshot address cannot move without a channel acknowledge;
- a lone channel acknowledge releases the channel;
- an enabled hit raises `irq`.

Only the bench's scenarios can show the parts that need the register map and chosen values:
- the exact inclusive window edges;
- the operation and client decoding, including out-of-range client ids;
- the captured field values;
- growth of the client set;
- the recapture on a simultaneous hit and acknowledge;
- isolation between channels.

// File: rtl/awu_pkg.sv
package awu_pkg;

    typedef enum logic [0:0] {
        CH_ARMED = 1'b0,
        CH_HELD  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_ACCUM   = 2'd2,
        ACT_RELEASE = 2'd3
    } ch_action_e;

    localparam int IDX_W = 4;

    // per-channel register indices
    localparam logic [IDX_W-1:0] IX_FIRST     = 4'd0;
    localparam logic [IDX_W-1:0] IX_LAST      = 4'd1;
    localparam logic [IDX_W-1:0] IX_OPMASK    = 4'd2;
    localparam logic [IDX_W-1:0] IX_CLIMASK   = 4'd3;
    localparam logic [IDX_W-1:0] IX_CAP_SET   = 4'd4;
    localparam logic [IDX_W-1:0] IX_CAP_ADDR  = 4'd5;
    localparam logic [IDX_W-1:0] IX_CAP_OP    = 4'd6;
    localparam logic [IDX_W-1:0] IX_CAP_FIRST = 4'd7;
    localparam logic [IDX_W-1:0] IX_CAP_SIZE  = 4'd8;
    localparam logic [IDX_W-1:0] IX_ACK       = 4'd9;
    localparam logic [IDX_W-1:0] IX_STATE     = 4'd10;

    // global register indices
    localparam logic [IDX_W-1:0] GX_ENABLE    = 4'd0;
    localparam logic [IDX_W-1:0] GX_STATUS    = 4'd1;
    localparam logic [IDX_W-1:0] GX_ACK       = 4'd2;

endpackage

// File: rtl/awu_match.sv
module awu_match #(
    parameter int AW   = 32,
    parameter int NOP  = 4,
    parameter int NCLI = 14,
    localparam int OPW  = $clog2(NOP),
    localparam int CIDW = $clog2(NCLI)
) (
    input  logic            acc_valid,
    input  logic [AW-1:0]   acc_addr,
    input  logic [OPW-1:0]  acc_op,
    input  logic [CIDW-1:0] acc_client,
    input  logic [AW-1:0]   lo_addr,
    input  logic [AW-1:0]   hi_addr,
    input  logic [NOP-1:0]  op_mask,
    input  logic [NCLI-1:0] cli_mask,
    output logic            hit
);

    logic in_range;
    logic op_sel;
    logic cli_sel;

    assign in_range = (acc_addr >= lo_addr) && (acc_addr <= hi_addr);

    always_comb begin
        op_sel = 1'b0;
        for (int k = 0; k < NOP; k++) begin
            if (acc_op == OPW'(k)) op_sel = op_mask[k];
        end
    end

    // ids with no mask bit leave cli_sel low
    always_comb begin
        cli_sel = 1'b0;
        for (int k = 0; k < NCLI; k++) begin
            if (acc_client == CIDW'(k)) cli_sel = cli_mask[k];
        end
    end

    assign hit = acc_valid && in_range && op_sel && cli_sel;

endmodule

// File: rtl/awu_channel.sv
module awu_channel
    import awu_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NOP  = 4,
    parameter int NCLI = 14,
    parameter int SZW  = 3,
    localparam int OPW  = $clog2(NOP),
    localparam int CIDW = $clog2(NCLI)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic            ack,
    input  logic [AW-1:0]   acc_addr,
    input  logic [OPW-1:0]  acc_op,
    input  logic [CIDW-1:0] acc_client,
    input  logic [SZW-1:0]  acc_size,
    output logic            held,
    output logic [NCLI-1:0] cap_set,
    output logic [AW-1:0]   cap_addr,
    output logic [OPW-1:0]  cap_op,
    output logic [CIDW-1:0] cap_first,
    output logic [SZW-1:0]  cap_size
);

    ch_state_e  state_q, state_d;
    ch_action_e act;
    logic [NCLI-1:0] cli_1h;

    always_comb begin
        for (int k = 0; k < NCLI; k++) begin
            cli_1h[k] = (acc_client == CIDW'(k));
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    // next state and action
    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        unique case (state_q)
            CH_ARMED: begin
                if (hit) begin
                    state_d = CH_HELD;
                    act     = ACT_CAPTURE;
                end
            end
            CH_HELD: begin
                if (hit && ack) begin
                    act = ACT_CAPTURE;
                end else if (hit) begin
                    act = ACT_ACCUM;
                end else if (ack) begin
                    state_d = CH_ARMED;
                    act     = ACT_RELEASE;
                end
            end
            default: state_d = CH_ARMED;
        endcase
    end

    // snapshot outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_set   <= '0;
            cap_addr  <= '0;
            cap_op    <= '0;
            cap_first <= '0;
            cap_size  <= '0;
        end else begin
            unique case (act)
                ACT_CAPTURE: begin
                    cap_set   <= cli_1h;
                    cap_addr  <= acc_addr;
                    cap_op    <= acc_op;
                    cap_first <= acc_client;
                    cap_size  <= acc_size;
                end
                ACT_ACCUM: cap_set <= cap_set | cli_1h;
                ACT_RELEASE: begin
                    cap_set   <= '0;
                    cap_addr  <= '0;
                    cap_op    <= '0;
                    cap_first <= '0;
                    cap_size  <= '0;
                end
                default: ;
            endcase
        end
    end

    assign held = (state_q == CH_HELD);

endmodule

// File: rtl/access_watch_unit.sv
module access_watch_unit
    import awu_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 32,
    parameter int NOP  = 4,
    parameter int NCLI = 14,
    parameter int SZW  = 3,
    parameter int DW   = 32,
    localparam int OPW  = $clog2(NOP),
    localparam int CIDW = $clog2(NCLI),
    localparam int CHW  = $clog2(NCH),
    localparam int RAW  = CHW + IDX_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [AW-1:0]   acc_addr,
    input  logic [OPW-1:0]  acc_op,
    input  logic [CIDW-1:0] acc_client,
    input  logic [SZW-1:0]  acc_size,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq
);

    logic             is_glb;
    logic [CHW-1:0]   sel_ch;
    logic [IDX_W-1:0] idx;

    assign is_glb = reg_addr[RAW-1];
    assign sel_ch = reg_addr[IDX_W +: CHW];
    assign idx    = reg_addr[IDX_W-1:0];

    logic [NCH-1:0][AW-1:0]   first_q, last_q;
    logic [NCH-1:0][NOP-1:0]  opmask_q;
    logic [NCH-1:0][NCLI-1:0] climask_q;
    logic [NCH-1:0]           en_q, pend_q;

    logic [NCH-1:0]           hit_vec, held_vec, chan_ack, gack;
    logic [NCH-1:0][NCLI-1:0] cap_set;
    logic [NCH-1:0][AW-1:0]   cap_addr;
    logic [NCH-1:0][OPW-1:0]  cap_op;
    logic [NCH-1:0][CIDW-1:0] cap_first;
    logic [NCH-1:0][SZW-1:0]  cap_size;

    // write strobes
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            chan_ack[k] = reg_we && !is_glb && (sel_ch == CHW'(k)) && (idx == IX_ACK);
        end
        gack = (reg_we && is_glb && idx == GX_ACK) ? reg_wdata[NCH-1:0] : '0;
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q   <= '0;
            last_q    <= '0;
            opmask_q  <= '0;
            climask_q <= '0;
            en_q      <= '0;
        end else if (reg_we) begin
            if (is_glb) begin
                if (idx == GX_ENABLE) en_q <= reg_wdata[NCH-1:0];
            end else begin
                for (int k = 0; k < NCH; k++) begin
                    if (sel_ch == CHW'(k)) begin
                        case (idx)
                            IX_FIRST:   first_q[k]   <= reg_wdata[AW-1:0];
                            IX_LAST:    last_q[k]    <= reg_wdata[AW-1:0];
                            IX_OPMASK:  opmask_q[k]  <= reg_wdata[NOP-1:0];
                            IX_CLIMASK: climask_q[k] <= reg_wdata[NCLI-1:0];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // pending bits: a hit beats a global acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= hit_vec | (pend_q & ~gack);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        awu_match #(.AW(AW), .NOP(NOP), .NCLI(NCLI)) u_match (
            .acc_valid  (acc_valid),
            .acc_addr   (acc_addr),
            .acc_op     (acc_op),
            .acc_client (acc_client),
            .lo_addr    (first_q[g]),
            .hi_addr    (last_q[g]),
            .op_mask    (opmask_q[g]),
            .cli_mask   (climask_q[g]),
            .hit        (hit_vec[g])
        );

        awu_channel #(.AW(AW), .NOP(NOP), .NCLI(NCLI), .SZW(SZW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit_vec[g]),
            .ack        (chan_ack[g]),
            .acc_addr   (acc_addr),
            .acc_op     (acc_op),
            .acc_client (acc_client),
            .acc_size   (acc_size),
            .held       (held_vec[g]),
            .cap_set    (cap_set[g]),
            .cap_addr   (cap_addr[g]),
            .cap_op     (cap_op[g]),
            .cap_first  (cap_first[g]),
            .cap_size   (cap_size[g])
        );
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (is_glb) begin
            case (idx)
                GX_ENABLE: reg_rdata = DW'(en_q);
                GX_STATUS: reg_rdata = DW'(pend_q & en_q);
                default:   reg_rdata = '0;
            endcase
        end else begin
            for (int k = 0; k < NCH; k++) begin
                if (sel_ch == CHW'(k)) begin
                    case (idx)
                        IX_FIRST:     reg_rdata = DW'(first_q[k]);
                        IX_LAST:      reg_rdata = DW'(last_q[k]);
                        IX_OPMASK:    reg_rdata = DW'(opmask_q[k]);
                        IX_CLIMASK:   reg_rdata = DW'(climask_q[k]);
                        IX_CAP_SET:   reg_rdata = DW'(cap_set[k]);
                        IX_CAP_ADDR:  reg_rdata = DW'(cap_addr[k]);
                        IX_CAP_OP:    reg_rdata = DW'(cap_op[k]);
                        IX_CAP_FIRST: reg_rdata = DW'(cap_first[k]);
                        IX_CAP_SIZE:  reg_rdata = DW'(cap_size[k]);
                        IX_STATE:     reg_rdata = DW'(held_vec[k]);
                        default:      reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign irq = |(pend_q & en_q);

endmodule

// File: rtl/awu_checker.sv
module awu_checker #(
    parameter int NCH = 4,
    parameter int AW  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [NCH-1:0]       hit,
    input logic [NCH-1:0]       held,
    input logic [NCH-1:0]       pend,
    input logic [NCH-1:0]       en,
    input logic [NCH-1:0]       chan_ack,
    input logic [NCH-1:0]       gack,
    input logic [NCH-1:0][AW-1:0] cap_addr,
    input logic                 irq
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> held[i]);

        p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (held[i] && !chan_ack[i]) |=> (held[i] && $stable(cap_addr[i])));

        p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_ack[i] && !hit[i]) |=> !held[i]);

        p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> pend[i]);

        p_gack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (gack[i] && !hit[i]) |=> !pend[i]);

        p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && en[i] && !reg_we) |=> irq);
    end

    p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

endmodule

bind access_watch_unit awu_checker #(.NCH(NCH), .AW(AW)) u_awu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .hit      (hit_vec),
    .held     (held_vec),
    .pend     (pend_q),
    .en       (en_q),
    .chan_ack (chan_ack),
    .gack     (gack),
    .cap_addr (cap_addr),
    .irq      (irq)
);

// File: tb/access_watch_unit_bench.sv
module access_watch_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_op = '0;
    logic [3:0]  acc_client = '0;
    logic [2:0]  acc_size = '0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    access_watch_unit u_access_watch_unit (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_op(acc_op),
        .acc_client(acc_client), .acc_size(acc_size),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {addr, op, client, expected hit} against channel 0:
    // window 0x1000..0x10FF, op mask write only (op 1), clients 3 and 5
    localparam logic [38:0] VEC [8] = '{
        {32'h0000_1000, 2'd1, 4'd3,  1'b1},
        {32'h0000_10FF, 2'd1, 4'd5,  1'b1},
        {32'h0000_0FFF, 2'd1, 4'd3,  1'b0},
        {32'h0000_1100, 2'd1, 4'd3,  1'b0},
        {32'h0000_1080, 2'd0, 4'd3,  1'b0},
        {32'h0000_1080, 2'd2, 4'd5,  1'b0},
        {32'h0000_1080, 2'd1, 4'd4,  1'b0},
        {32'h0000_1080, 2'd1, 4'd15, 1'b0}
    };

    function automatic logic [6:0] ca(input int ch, input int ix);
        return {1'b0, 2'(ch), 4'(ix)};
    endfunction

    function automatic logic [6:0] ga(input int ix);
        return {1'b1, 2'b00, 4'(ix)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_acc(input logic [31:0] a, input logic [1:0] op,
                           input logic [3:0] c, input logic [2:0] s);
        acc_valid = 1'b1; acc_addr = a; acc_op = op; acc_client = c; acc_size = s;
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] op,
                          input logic [3:0] c, input logic [2:0] s);
        @(negedge clk);
        set_acc(a, op, c, s);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // access and register write in the same cycle
    task automatic access_wr(input logic [31:0] a, input logic [1:0] op,
                             input logic [3:0] c, input logic [2:0] s,
                             input logic [6:0] ra, input logic [31:0] rd_v);
        @(negedge clk);
        set_acc(a, op, c, s);
        reg_we = 1'b1; reg_addr = ra; reg_wdata = rd_v;
        @(negedge clk);
        acc_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 irq", 32'(irq), 0);
        chk_reg("R11 status", ga(1), 0);
        chk_reg("R11 enable", ga(0), 0);
        chk_reg("R11 first", ca(0, 0), 0);
        chk_reg("R11 cap addr", ca(1, 5), 0);
        chk_reg("R11 held", ca(3, 10), 0);

        // channel 0 setup (R12 layout)
        wr(ca(0, 0), 32'h1000);
        wr(ca(0, 1), 32'h10FF);
        wr(ca(0, 2), 32'h2);
        wr(ca(0, 3), 32'h28);
        wr(ga(0), 32'h1);
        chk_reg("R12 last readback", ca(0, 1), 32'h10FF);

        // table walk: R1 R2 R3
        for (int v = 0; v < 8; v++) begin
            access(VEC[v][38:7], VEC[v][6:5], VEC[v][4:1], 3'd0);
            chk($sformatf("R1 R2 R3 table entry %0d status", v), reg_rdata & 0 | 0, 0);
            checks--;
            chk_reg($sformatf("R1 R2 R3 table entry %0d status", v), ga(1), 32'(VEC[v][0]));
            chk($sformatf("R1 R2 R3 table entry %0d irq", v), 32'(irq), 32'(VEC[v][0]));
            wr(ca(0, 9), 0);
            wr(ga(2), 32'hF);
        end

        // R4 capture
        access(32'h1010, 2'd1, 4'd3, 3'd2);
        chk("R4 irq", 32'(irq), 1);
        chk_reg("R4 held", ca(0, 10), 1);
        chk_reg("R4 cap addr", ca(0, 5), 32'h1010);
        chk_reg("R4 cap op", ca(0, 6), 1);
        chk_reg("R4 cap first", ca(0, 7), 3);
        chk_reg("R4 cap size", ca(0, 8), 2);
        chk_reg("R4 cap set", ca(0, 4), 32'h8);

        // R5 frozen, client set grows
        access(32'h1020, 2'd1, 4'd5, 3'd4);
        chk_reg("R5 cap addr", ca(0, 5), 32'h1010);
        chk_reg("R5 cap first", ca(0, 7), 3);
        chk_reg("R5 cap size", ca(0, 8), 2);
        chk_reg("R5 cap set", ca(0, 4), 32'h28);

        // R8 enable gating
        wr(ga(0), 32'h0);
        chk("R8 irq masked", 32'(irq), 0);
        chk_reg("R8 status masked", ga(1), 0);
        wr(ga(0), 32'h1);
        chk("R8 irq unmasked", 32'(irq), 1);

        // R7 global ack clears pending, snapshot stays
        wr(ga(2), 32'h1);
        chk_reg("R7 status after ack", ga(1), 0);
        chk("R7 irq after ack", 32'(irq), 0);
        chk_reg("R7 still held", ca(0, 10), 1);

        // R6 channel ack releases
        wr(ca(0, 9), 0);
        chk_reg("R6 held", ca(0, 10), 0);
        chk_reg("R6 cap addr", ca(0, 5), 0);
        chk_reg("R6 cap set", ca(0, 4), 0);

        // R7 hit beats global ack
        access(32'h1040, 2'd1, 4'd3, 3'd1);
        access_wr(32'h1044, 2'd1, 4'd3, 3'd1, ga(2), 32'h1);
        chk_reg("R7 hit wins", ga(1), 1);

        // R9 hit with channel ack recaptures
        access_wr(32'h1030, 2'd1, 4'd5, 3'd1, ca(0, 9), 0);
        chk_reg("R9 held", ca(0, 10), 1);
        chk_reg("R9 cap addr", ca(0, 5), 32'h1030);
        chk_reg("R9 cap first", ca(0, 7), 5);
        chk_reg("R9 cap set", ca(0, 4), 32'h20);
        wr(ca(0, 9), 0);
        wr(ga(2), 32'hF);

        // R10 independence
        wr(ca(2, 0), 32'h2000);
        wr(ca(2, 1), 32'h2FFF);
        wr(ca(2, 2), 32'h1);
        wr(ca(2, 3), 32'h3FFF);
        wr(ga(0), 32'h5);
        access(32'h1050, 2'd1, 4'd3, 3'd0);
        chk_reg("R10 only ch0", ga(1), 32'h1);
        chk_reg("R10 ch2 armed", ca(2, 10), 0);
        access(32'h2000, 2'd0, 4'd7, 3'd3);
        chk_reg("R10 both pending", ga(1), 32'h5);
        chk_reg("R10 ch2 cap addr", ca(2, 5), 32'h2000);
        chk_reg("R10 ch0 cap addr kept", ca(0, 5), 32'h1050);
        chk_reg("R10 ch1 armed", ca(1, 10), 0);
        chk_reg("R10 ch3 armed", ca(3, 10), 0);

        done = 1;
        finish_run();
    end

endmodule